// File: doc/BRIEF.md
# Read Delay Training Sequencer

This block trains the input-capture delay of a sixteen-lane memory data port. A one-cycle pulse on `start` launches a sweep. For each trial delay code, the block writes that code into every lane delay field. It then drives an external built-in self-test engine through eight test runs and checks whether the current delay captures data reliably.

The data-lane sweep keeps the lowest and the highest passing codes and programs the truncated average of the two. If no data-lane code passes, the lane delays go back to zero and the strobe delay is swept instead, from code 1 upward. The first strobe code that passes is kept.

When the block finishes, it raises `done` and holds it until the next start. `ok` tells whether a working code was found.

Top module: `rd_dly_trainer`

## Requirements
- R1: A one-cycle `start` while the block is idle begins training, clears `done` and `ok` on the following edge, and training runs until `done` rises. `done` then stays high until the next `start`. `ok` is low whenever `done` is low. A `start` during training is ignored.
- R2: One 5-bit lane code drives all sixteen lanes. `dly_lanes` holds sixteen 8-bit fields, with lane k in bits [8k+7:8k]. Each field carries the code zero-extended.
- R3: `dly_strobe` carries the strobe code zero-extended into both bits [31:24] and bits [23:16]. Bits [15:0] are zero.
- R4: Each test run writes three words in order, in consecutive cycles:
  - The control port receives zero.
  - The range port receives 0x1000007F.
  - The control port receives the start word: bit 0 = 1 (go), bit 1 = invert, bit 2 = randomize, bits [31:16] = pattern, all other bits zero.
- R5: Each delay setting runs up to eight tests, ordered by pattern and then by run index:
  - Pattern 0xFFFF runs first, with run index 0..3, then pattern 0xA55A with run index 0..3.
  - Run index bit 0 sets invert and bit 1 sets randomize.
- R6: After the start word, `bist_done` is sampled for at most 256 cycles. A run that never finishes is skipped and does not count as a failure.
- R7: A finished run with `bist_fail` high marks the setting as failing. The remaining runs for that setting are skipped, and the next setting starts again at run 0 of pattern 0xFFFF.
- R8: Data codes 0..31 are all tried in increasing order. The lowest passing code is the lower bound and the highest is the upper bound. The final lane code is (lower+upper)/2 truncated, with `ok` = 1.
- R9: If exactly one data code passes, that code is programmed.
- R10: If no data code passes, the lanes are set to 0 and strobe codes 1..31 are tried in order. Training ends with `ok` = 1 at the first passing strobe code, which stays programmed.
- R11: If nothing passes, training ends with `done` = 1, `ok` = 0, and both lane and strobe codes at zero.
- R12: In and right after reset, `done`, `ok`, all delays and both write strobes are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | One-cycle training request |
| bist_done | input | 1 | Self-test run finished |
| bist_fail | input | 1 | Self-test run found a mismatch (valid with bist_done) |
| bist_ctrl_we | output | 1 | Write strobe for the self-test control word |
| bist_ctrl_data | output | 32 | Control word: zero to clear, or start word |
| bist_range_we | output | 1 | Write strobe for the self-test range word |
| bist_range_data | output | 32 | Range word: start address and length |
| dly_lanes | output | 128 | Sixteen 8-bit lane delay fields |
| dly_strobe | output | 32 | Strobe delay word |
| done | output | 1 | Training finished |
| ok | output | 1 | A working delay was found (valid with done) |

## Verification
On every cycle, the assertions check the following:
- The lane and strobe words are packed as specified.
- The clear, range and start writes follow each other strictly.
- `done` holds until the next start, with no self-test traffic while it is high.
- A failed training leaves every delay at zero.

Only the bench scenarios can show which code is finally chosen. Its behavioural model of the self-test engine fails selected codes on a chosen run and hangs selected runs. It also checks that the eight start words arrive in pattern and run order and restart after each failure. Those scenarios cover midpoint selection, timeout skipping, the strobe fallback, total failure and an ignored restart.

// File: rtl/rd_dly_trainer.sv
module rd_dly_trainer #(
  parameter int          LANES      = 16,
  parameter int          CODE_W     = 5,
  parameter int          POLL_LIMIT = 256,
  parameter logic [31:0] TEST_ADDR  = 32'h0010_0000,
  parameter logic [31:0] TEST_LEN   = 32'h0000_8000,
  parameter logic [15:0] PAT_A      = 16'hFFFF,
  parameter logic [15:0] PAT_B      = 16'hA55A
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start,
  input  logic               bist_done,
  input  logic               bist_fail,
  output logic               bist_ctrl_we,
  output logic [31:0]        bist_ctrl_data,
  output logic               bist_range_we,
  output logic [31:0]        bist_range_data,
  output logic [LANES*8-1:0] dly_lanes,
  output logic [31:0]        dly_strobe,
  output logic               done,
  output logic               ok
);

  localparam int POLL_W = $clog2(POLL_LIMIT);
  localparam logic [CODE_W-1:0] CODE_MAX = '1;
  localparam logic [POLL_W-1:0] POLL_LAST = POLL_W'(POLL_LIMIT - 1);
  localparam logic [31:0] RANGE_WORD = ((TEST_ADDR << 8) & 32'hFFFF_0000) | ((TEST_LEN >> 8) - 32'd1);

  typedef enum logic [2:0] {S_IDLE, S_SET, S_CLR, S_RNG, S_GO, S_POLL, S_EVAL, S_MID} st_t;

  st_t               state;
  logic              strobe_ph, found, bad, pat_sel;
  logic [1:0]        run;
  logic [POLL_W-1:0] polls;
  logic [CODE_W-1:0] code, lo, hi, lane_code, strb_code, mid;
  logic              last_run;

  assign last_run = (run == 2'd3) && pat_sel;
  assign mid      = CODE_W'(({1'b0, lo} + {1'b0, hi}) >> 1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= S_IDLE;
      strobe_ph <= 1'b0;
      found     <= 1'b0;
      bad       <= 1'b0;
      pat_sel   <= 1'b0;
      run       <= '0;
      polls     <= '0;
      code      <= '0;
      lo        <= '0;
      hi        <= '0;
      lane_code <= '0;
      strb_code <= '0;
      done      <= 1'b0;
      ok        <= 1'b0;
    end else begin
      case (state)
        S_IDLE: if (start) begin
          done      <= 1'b0;
          ok        <= 1'b0;
          strobe_ph <= 1'b0;
          found     <= 1'b0;
          code      <= '0;
          lane_code <= '0;
          strb_code <= '0;
          state     <= S_SET;
        end
        S_SET: begin
          if (strobe_ph) strb_code <= code;
          else           lane_code <= code;
          pat_sel <= 1'b0;
          run     <= '0;
          bad     <= 1'b0;
          state   <= S_CLR;
        end
        S_CLR: state <= S_RNG;
        S_RNG: state <= S_GO;
        S_GO: begin
          polls <= '0;
          state <= S_POLL;
        end
        S_POLL: begin
          if (bist_done && bist_fail) begin
            bad   <= 1'b1;
            state <= S_EVAL;
          end else if (bist_done || polls == POLL_LAST) begin
            if (last_run) state <= S_EVAL;
            else begin
              if (run == 2'd3) pat_sel <= 1'b1;
              run   <= run + 2'd1;
              state <= S_CLR;
            end
          end else begin
            polls <= polls + 1'b1;
          end
        end
        S_EVAL: begin
          if (!strobe_ph) begin
            if (!bad) begin
              if (!found) lo <= code;
              hi    <= code;
              found <= 1'b1;
            end
            if (code == CODE_MAX) state <= S_MID;
            else begin
              code  <= code + 1'b1;
              state <= S_SET;
            end
          end else if (!bad) begin
            ok    <= 1'b1;
            done  <= 1'b1;
            state <= S_IDLE;
          end else if (code == CODE_MAX) begin
            strb_code <= '0;
            done      <= 1'b1;
            state     <= S_IDLE;
          end else begin
            code  <= code + 1'b1;
            state <= S_SET;
          end
        end
        S_MID: begin
          if (found) begin
            lane_code <= mid;
            ok        <= 1'b1;
            done      <= 1'b1;
            state     <= S_IDLE;
          end else begin
            strobe_ph <= 1'b1;
            code      <= CODE_W'(1);
            lane_code <= '0;
            state     <= S_SET;
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  assign bist_ctrl_we    = (state == S_CLR) || (state == S_GO);
  assign bist_ctrl_data  = (state == S_GO) ? {(pat_sel ? PAT_B : PAT_A), 13'd0, run[1], run[0], 1'b1} : 32'd0;
  assign bist_range_we   = (state == S_RNG);
  assign bist_range_data = bist_range_we ? RANGE_WORD : 32'd0;
  assign dly_strobe      = {8'(strb_code), 8'(strb_code), 16'd0};

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign dly_lanes[8*g +: 8] = 8'(lane_code);
  end

endmodule

// File: rtl/rd_dly_trainer_chk.sv
module rd_dly_trainer_chk #(
  parameter int LANES = 16
) (
  input logic               clk,
  input logic               rst_n,
  input logic               start,
  input logic               bist_ctrl_we,
  input logic [31:0]        bist_ctrl_data,
  input logic               bist_range_we,
  input logic [LANES*8-1:0] dly_lanes,
  input logic [31:0]        dly_strobe,
  input logic               done,
  input logic               ok
);

  function automatic logic lanes_same(input logic [LANES*8-1:0] v);
    logic r;
    r = (v[7:5] == 3'd0);
    for (int i = 1; i < LANES; i++) r = r && (v[8*i +: 8] == v[7:0]);
    return r;
  endfunction

  assert_lanes_equal_R2: assert property (@(posedge clk) disable iff (!rst_n)
    lanes_same(dly_lanes));

  assert_strobe_pack_R3: assert property (@(posedge clk) disable iff (!rst_n)
    dly_strobe[31:24] == dly_strobe[23:16] && dly_strobe[15:0] == 16'd0 && dly_strobe[31:29] == 3'd0);

  assert_range_after_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
    bist_range_we |-> $past(bist_ctrl_we && bist_ctrl_data == 32'd0));

  assert_go_after_range_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (bist_ctrl_we && bist_ctrl_data[0]) |-> $past(bist_range_we));

  assert_one_write_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({bist_ctrl_we, bist_range_we}));

  assert_done_holds_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !start) |=> done);

  assert_quiet_when_done_R1: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!bist_ctrl_we && !bist_range_we));

  assert_ok_needs_done_R1: assert property (@(posedge clk) disable iff (!rst_n)
    ok |-> done);

  assert_fail_zero_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !ok) |-> (dly_lanes == '0 && dly_strobe == 32'd0));

  assert_strobe_zero_lanes_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (dly_strobe != 32'd0) |-> (dly_lanes == '0));

endmodule

bind rd_dly_trainer rd_dly_trainer_chk #(.LANES(LANES)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start),
  .bist_ctrl_we(bist_ctrl_we), .bist_ctrl_data(bist_ctrl_data),
  .bist_range_we(bist_range_we), .dly_lanes(dly_lanes),
  .dly_strobe(dly_strobe), .done(done), .ok(ok)
);

// File: tb/rd_dly_trainer_bench.sv
`timescale 1ns/1ps
module rd_dly_trainer_bench;
  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
  logic b_done = 1'b0, b_fail = 1'b0;
  logic bist_ctrl_we, bist_range_we, done, ok;
  logic [31:0] bist_ctrl_data, bist_range_data, dly_strobe;
  logic [127:0] dly_lanes;

  always #2 clk = ~clk;

  rd_dly_trainer u_rd_dly_trainer (
    .clk(clk), .rst_n(rst_n), .start(start),
    .bist_done(b_done), .bist_fail(b_fail),
    .bist_ctrl_we(bist_ctrl_we), .bist_ctrl_data(bist_ctrl_data),
    .bist_range_we(bist_range_we), .bist_range_data(bist_range_data),
    .dly_lanes(dly_lanes), .dly_strobe(dly_strobe), .done(done), .ok(ok)
  );

  // self-test engine model
  logic [31:0] dm = '0, sm = '0, hm = '0;
  int fr = 0, lat_max = 1;
  logic model_rst = 1'b0;
  logic [2:0] seq = '0;
  int cnt = 0, proto_err = 0;
  logic hang = 1'b0, fv = 1'b0;

  function automatic logic [31:0] exp_word(input logic [2:0] s);
    return {(s[2] ? 16'hA55A : 16'hFFFF), 13'd0, s[1], s[0], 1'b1};
  endfunction

  always @(posedge clk) begin
    logic [4:0] c;
    logic bad_c, f, h;
    if (bist_range_we && bist_range_data != 32'h1000_007F) proto_err++;
    if (bist_ctrl_we && bist_ctrl_data == 32'd0) begin
      b_done <= 1'b0; cnt <= 0; hang <= 1'b0;
    end else if (bist_ctrl_we) begin
      if (bist_ctrl_data != exp_word(model_rst ? 3'd0 : seq)) proto_err++;   // R5
      c = (dly_strobe[28:24] != 5'd0) ? dly_strobe[28:24] : dly_lanes[4:0];
      bad_c = (dly_strobe[28:24] != 5'd0) ? !sm[c] : !dm[c];
      f = bad_c && (int'(seq) == fr);
      h = hm[c] && (int'(seq) == fr);
      fv <= f; hang <= h; b_done <= 1'b0;
      cnt <= 1 + int'($urandom % lat_max);
      seq <= (f && !h) ? 3'd0 : seq + 3'd1;                            // R7
    end else begin
      if (cnt > 0 && !hang) begin
        if (cnt == 1) begin b_done <= 1'b1; b_fail <= fv; end
        cnt <= cnt - 1;
      end
      if (model_rst) seq <= '0;
    end
  end

  int checks = 0, fails = 0;
  logic hung = 1'b0;

  task automatic chk(input logic cond, input string req, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (!cond) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int lowest(input logic [31:0] m);
    for (int i = 0; i < 32; i++) if (m[i]) return i;
    return -1;
  endfunction
  function automatic int highest(input logic [31:0] m);
    for (int i = 31; i >= 0; i--) if (m[i]) return i;
    return -1;
  endfunction

  task automatic run_case(input logic [31:0] d, input logic [31:0] s, input logic [31:0] h,
                          input int fidx, input int lat, input logic restart, input string req);
    logic [31:0] de, se;
    logic e_ok;
    int e_lane, e_strb, p0;
    if (hung) return;
    de = d | h;
    se = (s | h) & 32'hFFFF_FFFE;
    e_ok = 1'b1; e_lane = 0; e_strb = 0;
    if (de != 0) e_lane = (lowest(de) + highest(de)) / 2;
    else if (se != 0) e_strb = lowest(se);
    else e_ok = 1'b0;
    @(negedge clk);
    dm = d; sm = s; hm = h; fr = fidx; lat_max = lat;
    p0 = proto_err;
    start = 1'b1; model_rst = 1'b1;
    @(negedge clk);
    start = 1'b0; model_rst = 1'b0;
    chk(!done && !ok, "R1 done/ok cleared by start", {done, ok}, 0);
    if (restart) begin
      repeat (40) @(negedge clk);
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      chk(!done, "R1 restart while busy ignored", done, 0);
    end
    for (int n = 0; n < 30000 && !done; n++) @(negedge clk);
    if (!done) begin
      hung = 1'b1;
      chk(1'b0, "R1 watchdog expired", 0, 1);
      return;
    end
    chk(ok == e_ok, {req, " ok"}, ok, e_ok);
    chk(dly_lanes == {16{8'(e_lane)}}, {req, " R2 lane delays"}, dly_lanes, {16{8'(e_lane)}});
    chk(dly_strobe == {8'(e_strb), 8'(e_strb), 16'd0}, {req, " R3 strobe word"}, dly_strobe,
        {8'(e_strb), 8'(e_strb), 16'd0});
    chk(proto_err == p0, {req, " R4 R5 R7 write protocol"}, proto_err - p0, 0);
    repeat (3) @(negedge clk);
    chk(done, "R1 done held", done, 1);
  endtask

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    chk(!done && !ok && dly_lanes == 0 && dly_strobe == 0 && !bist_ctrl_we && !bist_range_we,
        "R12 reset state", {done, ok, bist_ctrl_we, bist_range_we}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!done && dly_lanes == 0 && !bist_ctrl_we, "R12 idle after reset", {done, bist_ctrl_we}, 0);

    run_case(32'h0003_FC00, 0, 0, 0, 3, 0, "R8 window 10..17");
    run_case(32'h0000_0020, 0, 0, 5, 2, 0, "R9 single code 5");
    run_case(32'hFFFF_FFFF, 0, 0, 7, 4, 0, "R8 full sweep");
    run_case(32'h4000_0008, 0, 0, 3, 2, 0, "R8 sparse 3 and 30");
    run_case(32'h8000_0000, 0, 0, 2, 1, 0, "R9 top code 31");
    run_case(32'h0000_0001, 0, 0, 6, 2, 0, "R9 code 0");
    run_case(0, 32'h0010_0080, 0, 1, 3, 0, "R10 strobe first pass 7");
    run_case(0, 32'h0000_0001, 0, 4, 2, 0, "R11 strobe zero never tried");
    run_case(0, 0, 0, 0, 2, 0, "R11 nothing passes");
    run_case(32'h0000_0010, 0, 32'h0000_0200, 5, 2, 0, "R6 hang on 9 counts as pass");
    run_case(0, 0, 32'h0000_1000, 7, 2, 0, "R6 hang in strobe sweep");
    run_case(32'h0000_0F00, 0, 0, 2, 3, 1, "R1 restart ignored window 8..11");
    for (int k = 0; k < 8; k++) begin
      logic [31:0] d, s;
      int a, b;
      a = int'($urandom % 32); b = a + int'($urandom % (32 - a));
      d = ((32'hFFFF_FFFF >> (31 - b)) & (32'hFFFF_FFFF << a));
      if ($urandom % 3 == 0) d = $urandom;
      if ($urandom % 4 == 0) d = 0;
      s = $urandom & $urandom;
      run_case(d, s, 0, int'($urandom % 8), 1 + int'($urandom % 5), 0, "R8 R10 random");
    end
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule